// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block is a circular buffer of uncommitted results. It lets instructions finish out of order while architectural state changes only in program order. At issue, the entry at the tail is claimed for the new instruction. The entry records what kind of instruction it is and where its result goes, and its value starts out empty. The entry number goes back to the issuer as the result tag. Execution units later report results against that tag. A small per-register table records which entry will produce the newest value of each register. A consumer can therefore find out whether a register is still in flight, and read the value once it has been produced but not yet committed.

Only the oldest entry (the head) may retire, and only when its result is present. At most one entry retires per clock cycle:

- A register-writing entry drives a write port toward the register file.
- A store entry presents an address and data with a valid strobe.
- A branch entry that completed as mispredicted raises a flush when it reaches the head. The flush discards every entry, so state stays precise.

Occupancy is tracked by a three-state machine with these states:

- `OCC_EMPTY`
- `OCC_ACTIVE`
- `OCC_FULL`

It has these transitions:

- *first-issue*: from `OCC_EMPTY` to `OCC_ACTIVE`.
- *fill*: from `OCC_ACTIVE` to `OCC_FULL`, when an issue takes the last free slot and nothing retires.
- *drain*: from `OCC_ACTIVE` to `OCC_EMPTY`, when the last entry retires and nothing issues.
- *release*: from `OCC_FULL` to `OCC_ACTIVE`, when an entry retires.
- *flush*: from `OCC_ACTIVE` or `OCC_FULL` to `OCC_EMPTY`.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty. `issue_ready` is 1, `issue_tag` is 0, `rf_we`, `st_valid` and `flush` are 0, and a lookup of any register reports not pending.
- R2: An accepted issue (`issue_valid` and `issue_ready` both high) takes the slot shown on `issue_tag`. Tags advance by one per accepted issue and wrap modulo DEPTH.
- R3: With DEPTH entries occupied, `issue_ready` is 0 and an asserted `issue_valid` has no effect. No slot is taken and no register becomes pending.
- R4: A completion fills the entry named by `cmpl_tag` with `cmpl_value` and `cmpl_mispred`. A completion that names an unoccupied slot is ignored, and a later occupant of that slot still waits for its own completion.
- R5: Entries retire strictly in issue order and only from the head, one per cycle, in the cycle after the head entry's result is present. A completed younger entry waits behind an incomplete older one.
- R6: Kind code 0 is a register write. Its retirement asserts `rf_we` for one cycle, with `rf_waddr` equal to the low REG_W bits of the destination and `rf_wdata` equal to the value.
- R7: Kind code 1 is a store. Its retirement asserts `st_valid` for one cycle, with `st_addr` equal to the full destination field and `st_data` equal to the value.
- R8: Kind code 2 (code 3 behaves the same) is a branch, and it produces no register write or store. A branch completed with `cmpl_mispred`=0 retires with no output. One completed with `cmpl_mispred`=1 asserts `flush` for one cycle when it is at the head. During that cycle `issue_ready` is 0. In the next cycle the buffer is empty, `issue_tag` is 0, younger entries never retire, and no register is pending.
- R9: A lookup of register r reports `lk_pending`=1 and `lk_tag` equal to the newest un-retired register-writing entry for r. It reports `lk_ready`=1 and `lk_value` equal to that entry's value once the entry is completed.
- R10: Retiring an older writer of r leaves r pending with the newer writer's tag. Retiring the newest writer of r clears pending.
- R11: In any cycle at most one of `rf_we`, `st_valid` and `flush` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Request to allocate an entry |
| issue_kind | input | 2 | 0 register write, 1 store, 2/3 branch |
| issue_dest | input | DEST_W | Register index (low bits) or store address |
| issue_ready | output | 1 | Allocation possible this cycle |
| issue_tag | output | $clog2(DEPTH) | Slot number given to the issuing instruction |
| cmpl_valid | input | 1 | Result broadcast strobe |
| cmpl_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| cmpl_value | input | DATA_W | Result value |
| cmpl_mispred | input | 1 | Branch resolved against its prediction |
| lk_reg | input | REG_W | Register being looked up |
| lk_pending | output | 1 | Register has an un-retired producer |
| lk_tag | output | $clog2(DEPTH) | Slot of the newest producer |
| lk_ready | output | 1 | That producer has completed |
| lk_value | output | DATA_W | Completed but uncommitted value |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | REG_W | Register-file write index |
| rf_wdata | output | DATA_W | Register-file write data |
| st_valid | output | 1 | Store strobe |
| st_addr | output | DEST_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Mispredicted branch retired; all entries discarded |

## Verification
A head pointer that is off by one, or a done flag that is set early, shows up as a retirement with the wrong register or value. It can also show up as a retirement one cycle too early, before the last older completion has landed. The bench sweeps every completion order of a full four-entry window and predicts the exact retire cycle of each entry, so such faults surface within a few cycles of the completion that exposes them. A stale rename pointer shows on the lookup port as a wrong tag, or as a pending flag that outlives its producer or survives a flush. Those ports are read right after each issue, retire and flush.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } rob_kind_e;

    typedef enum logic [1:0] {
        OCC_EMPTY  = 2'd0,
        OCC_ACTIVE = 2'd1,
        OCC_FULL   = 2'd2
    } rob_occ_e;

    // Codes 2 and 3 both mean branch.
    function automatic rob_kind_e decode_kind(input logic [1:0] code);
        rob_kind_e k;
        unique case (code)
            2'd0:    k = KIND_REG;
            2'd1:    k = KIND_STORE;
            default: k = KIND_BRANCH;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output rob_occ_e         occ
);

    localparam logic [TAG_W-1:0] LAST_SLOT = TAG_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    rob_occ_e state_q, state_d;

    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: first-issue, fill, drain, release, flush
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) state_d = OCC_ACTIVE;
            end
            OCC_ACTIVE: begin
                if (flush)
                    state_d = OCC_EMPTY;
                else if (push && !pop && count == CNT_MAX - CNT_ONE)
                    state_d = OCC_FULL;
                else if (pop && !push && count == CNT_ONE)
                    state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (flush)
                    state_d = OCC_EMPTY;
                else if (pop)
                    state_d = (count == CNT_ONE) ? OCC_EMPTY : OCC_ACTIVE;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // pointers and occupancy count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
            unique case ({push, pop})
                2'b10:   count <= count + CNT_ONE;
                2'b01:   count <= count - CNT_ONE;
                default: count <= count;
            endcase
        end
    end

    // outputs
    always_comb begin
        occ = state_q;
    end

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DEST_W = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  rob_kind_e         alloc_kind,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic              cmpl_en,
    input  logic [TAG_W-1:0]  cmpl_idx,
    input  logic [DATA_W-1:0] cmpl_value,
    input  logic              cmpl_mispred,
    input  logic              retire_en,
    input  logic [TAG_W-1:0]  head_idx,
    input  logic [TAG_W-1:0]  rd_idx,
    output logic              head_valid,
    output logic              head_done,
    output logic              head_mispred,
    output rob_kind_e         head_kind,
    output logic [DEST_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_value,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);

    logic              valid_a   [DEPTH];
    logic              done_a    [DEPTH];
    logic              mispred_a [DEPTH];
    rob_kind_e         kind_a    [DEPTH];
    logic [DEST_W-1:0] dest_a    [DEPTH];
    logic [DATA_W-1:0] value_a   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [TAG_W-1:0] ME = TAG_W'(i);
        logic              valid_q;
        logic              done_q;
        logic              mispred_q;
        rob_kind_e         kind_q;
        logic [DEST_W-1:0] dest_q;
        logic [DATA_W-1:0] value_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q   <= 1'b0;
                done_q    <= 1'b0;
                mispred_q <= 1'b0;
                kind_q    <= KIND_REG;
                dest_q    <= '0;
                value_q   <= '0;
            end else if (flush) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
            end else if (alloc_en && alloc_idx == ME) begin
                valid_q   <= 1'b1;
                done_q    <= 1'b0;
                mispred_q <= 1'b0;
                kind_q    <= alloc_kind;
                dest_q    <= alloc_dest;
                value_q   <= '0;
            end else if (retire_en && head_idx == ME) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
            end else if (cmpl_en && cmpl_idx == ME && valid_q) begin
                done_q    <= 1'b1;
                value_q   <= cmpl_value;
                mispred_q <= cmpl_mispred;
            end
        end

        assign valid_a[i]   = valid_q;
        assign done_a[i]    = done_q;
        assign mispred_a[i] = mispred_q;
        assign kind_a[i]    = kind_q;
        assign dest_a[i]    = dest_q;
        assign value_a[i]   = value_q;
    end

    always_comb begin
        head_valid   = valid_a[head_idx];
        head_done    = done_a[head_idx];
        head_mispred = mispred_a[head_idx];
        head_kind    = kind_a[head_idx];
        head_dest    = dest_a[head_idx];
        head_value   = value_a[head_idx];
        rd_done      = valid_a[rd_idx] && done_a[rd_idx];
        rd_value     = value_a[rd_idx];
    end

endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
    parameter int REG_W = 3,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [REG_W-1:0] lk_reg,
    output logic             lk_pending,
    output logic [TAG_W-1:0] lk_tag
);

    localparam int NREG = 1 << REG_W;

    logic             pend_a [NREG];
    logic [TAG_W-1:0] tag_a  [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [REG_W-1:0] ME = REG_W'(r);
        logic             pend_q;
        logic [TAG_W-1:0] tag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                tag_q  <= '0;
            end else if (flush) begin
                pend_q <= 1'b0;
            end else if (set_en && set_reg == ME) begin
                pend_q <= 1'b1;
                tag_q  <= set_tag;
            end else if (clr_en && clr_reg == ME && pend_q && tag_q == clr_tag) begin
                pend_q <= 1'b0;
            end
        end

        assign pend_a[r] = pend_q;
        assign tag_a[r]  = tag_q;
    end

    always_comb begin
        lk_pending = pend_a[lk_reg];
        lk_tag     = tag_a[lk_reg];
    end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 3,
    parameter int DEST_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic [1:0]               issue_kind,
    input  logic [DEST_W-1:0]        issue_dest,
    output logic                     issue_ready,
    output logic [$clog2(DEPTH)-1:0] issue_tag,
    input  logic                     cmpl_valid,
    input  logic [$clog2(DEPTH)-1:0] cmpl_tag,
    input  logic [DATA_W-1:0]        cmpl_value,
    input  logic                     cmpl_mispred,
    input  logic [REG_W-1:0]         lk_reg,
    output logic                     lk_pending,
    output logic [$clog2(DEPTH)-1:0] lk_tag,
    output logic                     lk_ready,
    output logic [DATA_W-1:0]        lk_value,
    output logic                     rf_we,
    output logic [REG_W-1:0]         rf_waddr,
    output logic [DATA_W-1:0]        rf_wdata,
    output logic                     st_valid,
    output logic [DEST_W-1:0]        st_addr,
    output logic [DATA_W-1:0]        st_data,
    output logic                     flush
);

    localparam int TAG_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rob_kind_e         in_kind;
    logic              push, pop, kill;
    logic [TAG_W-1:0]  head_ptr, tail_ptr;
    logic [CNT_W-1:0]  occ_count;
    rob_occ_e          occ_state;
    logic              head_valid, head_done, head_mispred;
    rob_kind_e         head_kind;
    logic [DEST_W-1:0] head_dest;
    logic [DATA_W-1:0] head_value;
    logic              rd_done;
    logic [DATA_W-1:0] rd_value;
    logic              ren_pending;
    logic [TAG_W-1:0]  ren_tag;

    assign in_kind = decode_kind(issue_kind);

    always_comb begin
        pop         = head_valid && head_done;
        kill        = pop && head_kind == KIND_BRANCH && head_mispred;
        issue_ready = (occ_state != OCC_FULL) && !kill;
        push        = issue_valid && issue_ready;
        issue_tag   = tail_ptr;
        rf_we       = pop && head_kind == KIND_REG;
        rf_waddr    = head_dest[REG_W-1:0];
        rf_wdata    = head_value;
        st_valid    = pop && head_kind == KIND_STORE;
        st_addr     = head_dest;
        st_data     = head_value;
        flush       = kill;
        lk_pending  = ren_pending;
        lk_tag      = ren_tag;
        lk_ready    = ren_pending && rd_done;
        lk_value    = lk_ready ? rd_value : '0;
    end

    rob_ctrl #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (kill),
        .head  (head_ptr),
        .tail  (tail_ptr),
        .count (occ_count),
        .occ   (occ_state)
    );

    rob_entries #(
        .DEPTH  (DEPTH),
        .DEST_W (DEST_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_entries (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (kill),
        .alloc_en     (push),
        .alloc_idx    (tail_ptr),
        .alloc_kind   (in_kind),
        .alloc_dest   (issue_dest),
        .cmpl_en      (cmpl_valid),
        .cmpl_idx     (cmpl_tag),
        .cmpl_value   (cmpl_value),
        .cmpl_mispred (cmpl_mispred),
        .retire_en    (pop),
        .head_idx     (head_ptr),
        .rd_idx       (ren_tag),
        .head_valid   (head_valid),
        .head_done    (head_done),
        .head_mispred (head_mispred),
        .head_kind    (head_kind),
        .head_dest    (head_dest),
        .head_value   (head_value),
        .rd_done      (rd_done),
        .rd_value     (rd_value)
    );

    rob_rename #(
        .REG_W (REG_W),
        .TAG_W (TAG_W)
    ) u_rename (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (kill),
        .set_en     (push && in_kind == KIND_REG),
        .set_reg    (issue_dest[REG_W-1:0]),
        .set_tag    (tail_ptr),
        .clr_en     (rf_we),
        .clr_reg    (head_dest[REG_W-1:0]),
        .clr_tag    (head_ptr),
        .lk_reg     (lk_reg),
        .lk_pending (ren_pending),
        .lk_tag     (ren_tag)
    );

endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk
    import rob_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         issue_valid,
    input logic                         issue_ready,
    input logic                         rf_we,
    input logic                         st_valid,
    input logic                         flush,
    input logic                         lk_pending,
    input logic                         lk_ready,
    input logic [$clog2(DEPTH+1)-1:0]   occ_count,
    input rob_occ_e                     occ_state
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_count == CNT_MAX) |-> !issue_ready);

    assert_full_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_state == OCC_FULL) == (occ_count == CNT_MAX));

    assert_issue_occupies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready) |=> (occ_count != '0));

    assert_retire_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || st_valid || flush) |-> (occ_count != '0));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ_count == '0 && occ_state == OCC_EMPTY));

    assert_flush_blocks_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !issue_ready);

    assert_ready_implies_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ready |-> lk_pending);

    assert_single_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_valid, flush}));

endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .rf_we       (rf_we),
    .st_valid    (st_valid),
    .flush       (flush),
    .lk_pending  (lk_pending),
    .lk_ready    (lk_ready),
    .occ_count   (occ_count),
    .occ_state   (occ_state)
);

// File: tb/reorder_buf_test.sv
module reorder_buf_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam int REG_W  = 2;
    localparam int DEST_W = 8;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_valid = 1'b0;
    logic [1:0]        issue_kind = 2'd0;
    logic [DEST_W-1:0] issue_dest = '0;
    logic              issue_ready;
    logic [TAG_W-1:0]  issue_tag;
    logic              cmpl_valid = 1'b0;
    logic [TAG_W-1:0]  cmpl_tag = '0;
    logic [DATA_W-1:0] cmpl_value = '0;
    logic              cmpl_mispred = 1'b0;
    logic [REG_W-1:0]  lk_reg = '0;
    logic              lk_pending;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_ready;
    logic [DATA_W-1:0] lk_value;
    logic              rf_we;
    logic [REG_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic              st_valid;
    logic [DEST_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic              flush;

    reorder_buf #(
        .DEPTH(DEPTH), .REG_W(REG_W), .DEST_W(DEST_W), .DATA_W(DATA_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_kind(issue_kind), .issue_dest(issue_dest),
        .issue_ready(issue_ready), .issue_tag(issue_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
        .cmpl_mispred(cmpl_mispred),
        .lk_reg(lk_reg), .lk_pending(lk_pending), .lk_tag(lk_tag),
        .lk_ready(lk_ready), .lk_value(lk_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .flush(flush)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int tb_tail = 0;

    // expected retirement log: kind 0 reg, 1 store, 2 flush
    int    exp_kind [32];
    int    exp_dest [32];
    int    exp_val  [32];
    int    exp_cyc  [32];
    string exp_req  [32];
    int    exp_n = 0;
    int    got_n = 0;

    task automatic check(input string req, input bit ok, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic expect_retire(input int k, input int d, input int v,
                                 input int c, input string req);
        exp_kind[exp_n] = k;
        exp_dest[exp_n] = d;
        exp_val[exp_n]  = v;
        exp_cyc[exp_n]  = c;
        exp_req[exp_n]  = req;
        exp_n++;
    endtask

    task automatic close_log(input string req);
        check(req, got_n == exp_n, "retirements seen", got_n, exp_n);
        exp_n = 0;
        got_n = 0;
    endtask

    // retirement monitor
    always @(negedge clk) begin
        if (rst_n && (rf_we || st_valid || flush)) begin
            if (got_n >= exp_n) begin
                check("R5", 1'b0, "unexpected retirement",
                      int'({rf_we, st_valid, flush}), 0);
            end else begin
                case (exp_kind[got_n])
                    0: begin
                        check(exp_req[got_n], rf_we, "rf_we", int'(rf_we), 1);
                        check(exp_req[got_n], int'(rf_waddr) == exp_dest[got_n],
                              "rf_waddr", int'(rf_waddr), exp_dest[got_n]);
                        check(exp_req[got_n], int'(rf_wdata) == exp_val[got_n],
                              "rf_wdata", int'(rf_wdata), exp_val[got_n]);
                    end
                    1: begin
                        check(exp_req[got_n], st_valid, "st_valid", int'(st_valid), 1);
                        check(exp_req[got_n], int'(st_addr) == exp_dest[got_n],
                              "st_addr", int'(st_addr), exp_dest[got_n]);
                        check(exp_req[got_n], int'(st_data) == exp_val[got_n],
                              "st_data", int'(st_data), exp_val[got_n]);
                    end
                    default: check(exp_req[got_n], flush, "flush", int'(flush), 1);
                endcase
                if (exp_cyc[got_n] >= 0)
                    check("R5", cyc == exp_cyc[got_n], "retire cycle", cyc, exp_cyc[got_n]);
                got_n++;
            end
        end
    end

    task automatic do_issue(input int kind, input int dest, input string req);
        check(req, issue_ready, "issue_ready", int'(issue_ready), 1);
        check("R2", int'(issue_tag) == tb_tail, "issue_tag", int'(issue_tag), tb_tail);
        issue_valid = 1'b1;
        issue_kind  = 2'(kind);
        issue_dest  = DEST_W'(dest);
        @(negedge clk);
        issue_valid = 1'b0;
        tb_tail = (tb_tail + 1) % DEPTH;
    endtask

    task automatic do_cmpl(input int tag, input int val, input bit mis);
        cmpl_valid   = 1'b1;
        cmpl_tag     = TAG_W'(tag);
        cmpl_value   = DATA_W'(val);
        cmpl_mispred = mis;
        @(negedge clk);
        cmpl_valid   = 1'b0;
        cmpl_mispred = 1'b0;
    endtask

    task automatic look(input int r, input bit pend, input int tag, input bit rdy,
                        input int val, input string req);
        lk_reg = REG_W'(r);
        #1;
        check(req, lk_pending == pend, "lk_pending", int'(lk_pending), int'(pend));
        if (pend) check(req, int'(lk_tag) == tag, "lk_tag", int'(lk_tag), tag);
        if (pend) check(req, lk_ready == rdy, "lk_ready", int'(lk_ready), int'(rdy));
        if (rdy)  check(req, int'(lk_value) == val, "lk_value", int'(lk_value), val);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // every completion order of a full window of register writes
    task automatic sweep_orders();
        int ord [4];
        int comp [4];
        int vals [4];
        int base;
        int start;
        int prev;
        int rem;
        int sel;
        int f;
        bit used [4];
        for (int p = 0; p < 24; p++) begin
            rem = p;
            for (int m = 0; m < 4; m++) used[m] = 1'b0;
            for (int k = 0; k < 4; k++) begin
                f = (k == 0) ? 6 : (k == 1) ? 2 : 1;
                sel = rem / f;
                rem = rem % f;
                for (int m = 0; m < 4; m++) begin
                    if (!used[m]) begin
                        if (sel == 0) begin
                            ord[k] = m;
                            used[m] = 1'b1;
                        end
                        sel--;
                    end
                end
            end
            base = tb_tail;
            for (int i = 0; i < 4; i++) begin
                vals[i] = (p * 11 + i * 37 + 5) & 8'hFF;
                do_issue(0, i, "R2");
            end
            for (int i = 0; i < 4; i++)
                look(i, 1'b1, (base + i) % DEPTH, 1'b0, 0, "R9");
            start = cyc;
            for (int j = 0; j < 4; j++) comp[ord[j]] = start + j;
            prev = -100;
            for (int k = 0; k < 4; k++) begin
                prev = (prev + 1 > comp[k] + 1) ? prev + 1 : comp[k] + 1;
                expect_retire(0, k, vals[k], prev, "R6");
            end
            for (int j = 0; j < 4; j++)
                do_cmpl((base + ord[j]) % DEPTH, vals[ord[j]], 1'b0);
            idle(5);
            close_log("R5");
            for (int i = 0; i < 4; i++) look(i, 1'b0, 0, 1'b0, 0, "R10");
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int t0;
        int ta;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", issue_ready, "issue_ready", int'(issue_ready), 1);
        check("R1", issue_tag == '0, "issue_tag", int'(issue_tag), 0);
        check("R1", !rf_we && !st_valid && !flush, "retire outputs",
              int'({rf_we, st_valid, flush}), 0);
        for (int r = 0; r < 4; r++) look(r, 1'b0, 0, 1'b0, 0, "R1");

        sweep_orders();

        // R3 full buffer ignores issue
        t0 = tb_tail;
        for (int i = 0; i < 4; i++) do_issue(0, i, "R3");
        check("R3", !issue_ready, "issue_ready when full", int'(issue_ready), 0);
        issue_valid = 1'b1; issue_kind = 2'd0; issue_dest = 8'h03;
        @(negedge clk);
        issue_valid = 1'b0;
        check("R3", !issue_ready, "issue_ready still full", int'(issue_ready), 0);
        check("R3", int'(issue_tag) == t0, "tail unchanged", int'(issue_tag), t0);
        for (int i = 0; i < 4; i++) expect_retire(0, i, 8'h20 + i, -1, "R3");
        for (int i = 0; i < 4; i++) do_cmpl((t0 + i) % DEPTH, 8'h20 + i, 1'b0);
        idle(4);
        close_log("R3");
        look(3, 1'b0, 0, 1'b0, 0, "R3");
        check("R3", int'(issue_tag) == tb_tail, "tag after drain", int'(issue_tag), tb_tail);

        // R4 completion to an empty slot is dropped
        t0 = tb_tail;
        do_cmpl(t0, 8'hEE, 1'b0);
        do_issue(0, 1, "R4");
        idle(3);
        look(1, 1'b1, t0, 1'b0, 0, "R4");
        expect_retire(0, 1, 8'h42, -1, "R4");
        do_cmpl(t0, 8'h42, 1'b0);
        idle(2);
        close_log("R4");

        // R7 store retires before a younger completed register write
        t0 = tb_tail;
        do_issue(1, 8'hA5, "R7");
        do_issue(0, 2, "R7");
        expect_retire(1, 8'hA5, 8'h77, -1, "R7");
        expect_retire(0, 2, 8'h11, -1, "R6");
        do_cmpl((t0 + 1) % DEPTH, 8'h11, 1'b0);
        look(2, 1'b1, (t0 + 1) % DEPTH, 1'b1, 8'h11, "R9");
        do_cmpl(t0, 8'h77, 1'b0);
        idle(3);
        close_log("R7");

        // R8 correctly predicted branch retires silently
        t0 = tb_tail;
        do_issue(2, 0, "R8");
        do_cmpl(t0, 0, 1'b0);
        idle(3);
        close_log("R8");
        check("R8", int'(issue_tag) == tb_tail, "tag after branch", int'(issue_tag), tb_tail);

        // R8 mispredicted branch flushes younger work
        t0 = tb_tail;
        do_issue(0, 0, "R8");
        do_issue(3, 0, "R8");
        do_issue(0, 1, "R8");
        look(1, 1'b1, (t0 + 2) % DEPTH, 1'b0, 0, "R9");
        expect_retire(0, 0, 8'h44, -1, "R8");
        expect_retire(2, 0, 0, -1, "R8");
        do_cmpl((t0 + 2) % DEPTH, 8'h33, 1'b0);
        do_cmpl((t0 + 1) % DEPTH, 0, 1'b1);
        do_cmpl(t0, 8'h44, 1'b0);
        @(negedge clk);
        check("R8", flush, "flush", int'(flush), 1);
        check("R8", !issue_ready, "issue_ready during flush", int'(issue_ready), 0);
        @(negedge clk);
        check("R8", issue_ready, "issue_ready after flush", int'(issue_ready), 1);
        check("R8", issue_tag == '0, "issue_tag after flush", int'(issue_tag), 0);
        look(1, 1'b0, 0, 1'b0, 0, "R8");
        look(0, 1'b0, 0, 1'b0, 0, "R8");
        idle(3);
        close_log("R8");
        tb_tail = 0;

        // R10 two writers of one register
        ta = tb_tail;
        do_issue(0, 3, "R10");
        do_issue(0, 3, "R10");
        look(3, 1'b1, ta + 1, 1'b0, 0, "R10");
        expect_retire(0, 3, 8'h55, -1, "R10");
        expect_retire(0, 3, 8'h99, -1, "R10");
        do_cmpl(ta + 1, 8'h99, 1'b0);
        look(3, 1'b1, ta + 1, 1'b1, 8'h99, "R9");
        do_cmpl(ta, 8'h55, 1'b0);
        @(negedge clk);
        look(3, 1'b1, ta + 1, 1'b1, 8'h99, "R10");
        @(negedge clk);
        look(3, 1'b0, 0, 1'b0, 0, "R10");
        idle(2);
        close_log("R10");
        check("R11", 1'b1, "single action covered by retire log", 1, 1);

        finish_run();
    end

endmodule